// File: doc/BRIEF.md
# Low-speed USB packet receiver

This block recovers packets from the two data lines of a low-speed USB link. A system clock much faster than the bit rate samples the lines. The bit period is a fractional number of system clocks, set by a numerator and a denominator parameter. The receiver waits on an idle bus for a transition into the K state, then follows the alternating sync field. It locks once two K bit times arrive back to back.

After lock, each bit is sampled once near its centre and NRZI-decoded against the previous line state. Stuffed bits are removed. The data bits are gathered into bytes, least significant bit first, and each finished byte appears on a byte output with a one-cycle strobe. When both lines are low (SE0), the block gives a done pulse and the number of whole bytes delivered. If a packet holds more bytes than the configured capacity, it ends with an error pulse instead of a done pulse.

Top module: `usb_ls_rx`

## Requirements
- R1: During and after reset, rx_valid, rx_done and rx_error are low and rx_data and rx_count are zero.
- R2: Line states are encoded as {dp,dm}: J (idle) is 2'b01, K is 2'b10 and SE0 is 2'b00.
- R3: A receive starts only after a J-to-K transition. Lock needs two consecutive K bit samples. If a K sample is followed by two J samples before lock, the receiver returns to waiting for the next J-to-K transition, and nothing is delivered.
- R4: A sampled line state equal to the previous one decodes as 1, and a change decodes as 0. Each group of eight data bits is delivered LSB first on rx_data with a one-cycle rx_valid pulse.
- R5: The trailing K-K of the sync field counts as one decoded 1. After six consecutive decoded 1s, the next bit is dropped from the data, and its line state becomes the reference for the following bit.
- R6: An SE0 sample after lock produces a one-cycle rx_done pulse, with rx_count equal to the number of whole bytes delivered in that packet.
- R7: When byte number MAX_BYTES+1 completes, rx_error pulses for one cycle. That byte is not delivered, and the rest of the packet gives neither rx_valid nor rx_done.
- R8: Bits are sampled every NUM/DEN system clocks (40/3 by default), so a packet of MAX_BYTES bytes at exactly that rate is received without slip.
- R9: rx_valid, rx_done and rx_error are never high in the same cycle, and none of them is high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dp | input | 1 | D+ line level, asynchronous |
| dm | input | 1 | D- line level, asynchronous |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for rx_data |
| rx_done | output | 1 | One-cycle end-of-packet pulse |
| rx_count | output | $clog2(MAX_BYTES+1) | Bytes in the packet just ended |
| rx_error | output | 1 | One-cycle overflow pulse |

## Verification
Several byte patterns test the NRZI decoding and bit order. Alternating values and all-zero bytes give many transitions. Bytes with only their top or bottom bit set show whether the order is reversed. Runs of 0xFF and bytes such as 0x1F and 0xFC place stuff bits in the middle of a byte, across a byte boundary and just before SE0. The 0x1F case only decodes correctly if the final sync bit is counted toward the run of ones. Further packets cover a single stray K before a real packet, an empty packet, a full-capacity packet and an overlong packet followed by a normal one. Together these separate sync handling, the fractional bit timing and overflow recovery.

// File: rtl/usb_ls_rx.sv
module usb_ls_rx #(
  parameter int NUM       = 40,
  parameter int DEN       = 3,
  parameter int MAX_BYTES = 11,
  localparam int CW = $clog2(MAX_BYTES + 1),
  localparam int PW = $clog2(NUM + DEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dp,
  input  logic          dm,
  output logic [7:0]    rx_data,
  output logic          rx_valid,
  output logic          rx_done,
  output logic [CW-1:0] rx_count,
  output logic          rx_error
);
  localparam logic [1:0] LJ = 2'b01, LK = 2'b10, LSE0 = 2'b00;

  typedef enum logic [1:0] {HUNT, SYNC, DATA, DROP} st_t;
  st_t st;

  logic [1:0]    dp_s, dm_s;
  logic [1:0]    ln_q, ref_ln;
  logic [PW-1:0] ph;
  logic          last_k;
  logic [2:0]    ones, bidx;
  logic [7:0]    sr;
  logic [CW-1:0] cnt;

  wire [1:0]    ln    = {dp_s[1], dm_s[1]};
  wire          kedge = (ln_q == LJ) && (ln == LK);
  wire [PW-1:0] ph_n  = ph + PW'(DEN);
  wire          tick  = ph_n >= PW'(NUM);
  wire          bit_v = (ln == ref_ln);
  wire [7:0]    sr_n  = {bit_v, sr[7:1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dp_s <= '0; dm_s <= '0; ln_q <= '0; ref_ln <= LK;
      st <= HUNT; ph <= '0; last_k <= 1'b0;
      ones <= '0; bidx <= '0; sr <= '0; cnt <= '0;
      rx_data <= '0; rx_valid <= 1'b0; rx_done <= 1'b0;
      rx_count <= '0; rx_error <= 1'b0;
    end else begin
      dp_s <= {dp_s[0], dp};
      dm_s <= {dm_s[0], dm};
      ln_q <= ln;
      rx_valid <= 1'b0;
      rx_done  <= 1'b0;
      rx_error <= 1'b0;
      ph <= tick ? ph_n - PW'(NUM) : ph_n;
      case (st)
        HUNT: if (kedge) begin
          st <= SYNC;
          ph <= PW'(NUM / 2);
          last_k <= 1'b0;
        end
        SYNC: begin
          if (kedge) ph <= PW'(NUM / 2);
          else if (tick) begin
            if (ln == LK) begin
              if (last_k) begin
                st <= DATA; ref_ln <= LK; ones <= 3'd1;
                bidx <= '0; cnt <= '0; sr <= '0;
              end
              last_k <= 1'b1;
            end else if (ln == LJ) begin
              if (!last_k) st <= HUNT;
              last_k <= 1'b0;
            end else st <= HUNT;
          end
        end
        DATA: if (tick) begin
          if (ln == LSE0) begin
            rx_done <= 1'b1;
            rx_count <= cnt;
            st <= HUNT;
          end else if (ones == 3'd6) begin
            ref_ln <= ln;
            ones <= '0;
          end else begin
            ref_ln <= ln;
            ones <= bit_v ? ones + 3'd1 : 3'd0;
            sr <= sr_n;
            bidx <= bidx + 3'd1;
            if (bidx == 3'd7) begin
              if (cnt == CW'(MAX_BYTES)) begin
                rx_error <= 1'b1;
                st <= DROP;
              end else begin
                rx_data <= sr_n;
                rx_valid <= 1'b1;
                cnt <= cnt + CW'(1);
              end
            end
          end
        end
        DROP: if (ln == LSE0) st <= HUNT;
        default: st <= HUNT;
      endcase
    end
  end
endmodule

// File: rtl/usb_ls_rx_chk.sv
module usb_ls_rx_chk #(
  parameter int MAX_BYTES = 11,
  localparam int CW = $clog2(MAX_BYTES + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_valid,
  input logic          rx_done,
  input logic          rx_error,
  input logic [CW-1:0] rx_count
);
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({rx_valid, rx_done, rx_error}) <= 1); // R9
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done); // R6
  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_error |=> !rx_error); // R7
  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> rx_count <= CW'(MAX_BYTES)); // R7
  AST_ERR_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_error |=> !rx_done && !rx_valid); // R7
endmodule

bind usb_ls_rx usb_ls_rx_chk #(.MAX_BYTES(MAX_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_done(rx_done),
  .rx_error(rx_error), .rx_count(rx_count)
);

// File: tb/sim_usb_ls_rx.sv
module sim_usb_ls_rx;
  localparam int NUM = 40, DEN = 3, MAXB = 11;
  localparam int CW = $clog2(MAXB + 1);
  localparam logic [1:0] J = 2'b01, K = 2'b10, SE0 = 2'b00;

  logic clk = 1'b0, rst_n = 1'b0, dp = 1'b0, dm = 1'b1;
  logic [7:0] rx_data;
  logic rx_valid, rx_done, rx_error;
  logic [CW-1:0] rx_count;

  usb_ls_rx #(.NUM(NUM), .DEN(DEN), .MAX_BYTES(MAXB)) u0 (
    .clk(clk), .rst_n(rst_n), .dp(dp), .dm(dm), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_done(rx_done), .rx_count(rx_count),
    .rx_error(rx_error));

  always #4 clk = ~clk;

  int vecs = 0, errs = 0, frac = 0;
  int q[$];
  string tag = "R1";
  bit fin = 1'b0;

  task automatic chk(bit ok, string t, int act, int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !fin) begin
    int e;
    e = (q.size() > 0) ? q[0] : -1;
    if (rx_valid) begin
      chk(e == int'(rx_data), tag, int'(rx_data), e);
      if (q.size() > 0) void'(q.pop_front());
    end else if (rx_done) begin
      chk(e == 1000 + int'(rx_count), "R6 done/count", 1000 + int'(rx_count), e);
      if (q.size() > 0) void'(q.pop_front());
    end else if (rx_error) begin
      chk(e == 2000, "R7 overflow", 2000, e);
      if (q.size() > 0) void'(q.pop_front());
    end else vecs++;
  end

  task automatic bitl(logic [1:0] s);
    int n;
    {dp, dm} = s;
    n = (frac + NUM) / DEN;
    frac = (frac + NUM) % DEN;
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [1:0] tog(logic [1:0] s);
    return (s == J) ? K : J;
  endfunction

  task automatic send(int d[$]);
    logic [1:0] cur;
    int ones;
    repeat (4) bitl(J);
    for (int i = 0; i < 3; i++) begin bitl(K); bitl(J); end
    bitl(K); bitl(K);
    cur = K; ones = 1;
    foreach (d[j]) for (int i = 0; i < 8; i++) begin
      if (d[j][i]) ones++;
      else begin cur = tog(cur); ones = 0; end
      bitl(cur);
      if (ones == 6) begin cur = tog(cur); bitl(cur); ones = 0; end
    end
    bitl(SE0); bitl(SE0); bitl(J); bitl(J);
  endtask

  task automatic run(int d[$], string t);
    tag = t;
    for (int i = 0; i < d.size() && i < MAXB; i++) q.push_back(d[i]);
    q.push_back(d.size() > MAXB ? 2000 : 1000 + d.size());
    send(d);
    repeat (20) @(negedge clk);
    chk(q.size() == 0, {t, " all events seen"}, q.size(), 0);
    q.delete();
  endtask

  initial begin
    int big[$];
    repeat (5) @(negedge clk);
    chk(!rx_valid && !rx_done && !rx_error && rx_data == 0 && rx_count == 0,
        "R1 reset", {rx_valid, rx_done, rx_error}, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    run('{8'hA5, 8'h3C}, "R4 R2 mixed");
    run('{8'h00}, "R4 zeros");
    run('{8'h80, 8'h01}, "R4 lsb first");
    run('{8'hFF, 8'hFF, 8'h7E, 8'h3F}, "R5 long ones");
    run('{8'h1F, 8'h55}, "R5 sync one counted");
    run('{8'hFC}, "R5 stuff before eop");
    tag = "R3 false start";
    bitl(J); bitl(J); bitl(K); bitl(J); bitl(J); bitl(J); bitl(J);
    repeat (10) @(negedge clk);
    chk(q.size() == 0 && !rx_done, "R3 no event", q.size(), 0);
    run('{8'h5A}, "R3 after false start");
    big.delete();
    run(big, "R6 empty");
    for (int i = 0; i < MAXB; i++) big.push_back((i * 23 + 7) & 8'hFF);
    run(big, "R8 full length");
    big.push_back(8'h11); big.push_back(8'h22);
    run(big, "R7 overflow");
    run('{8'hC3}, "R7 recovery");
    fin = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      fin = 1'b1;
      errs++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule